// File: doc/BRIEF.md
# Multiplier-free lookup-table dense layer

This block computes one fully connected neural layer without a single multiply. Every connection from an input activation to an output neuron is its own small one-input lookup table. The table turns the input value into a signed contribution, and each output neuron adds up the contributions from all of its inputs. The table contents and the address and result widths of each connection are fixed when the block is built. A connection whose address width or result width is zero is dropped and adds nothing.

All inputs arrive in parallel as signed fixed-point words and are captured in an input register. Each connection forms its table address from only the low bits of the input word. Those bits are simply cut off, so no comparison or clamping is needed. The looked-up code is sign-extended to the accumulator width. A balanced adder tree, registered at every level, produces one sum per output. A valid strobe travels alongside the data so that the result is marked valid a fixed number of cycles later. A new input vector can be accepted on every cycle. There is no backpressure.

Top module: `lutmap_layer`

## Requirements
- R1: Each output `o` equals the sum over all inputs `i` of the contribution of connection (o,i). The connection index is `e = o*N_IN + i`, and output `o` is read from `out_sum[o*AW +: AW]` as a two's-complement value, where `AW = MAXW + ceil(log2 N_IN)`. No multiplication is used.
- R2: The table address of connection `e` is the low `b_in(e)` bits of input word `i`, taken from `in_act[i*XW +: XW]`. The field `b_in(e)` is `IN_W[e*4 +: 4]`. Input bits at and above position `b_in(e)` have no effect on that contribution.
- R3: Entry `a` of connection `e` is found at bit `(e*2^MAXW + a)*MAXW` of `TABLES`. Only its low `b_out(e)` bits are used, where `b_out(e)` is `OUT_W[e*4 +: 4]`, and they are read as a two's-complement number. For example, the 1-bit code 1 contributes -1. Table bits above `b_out(e)` are ignored.
- R4: A connection with `b_in = 0` or `b_out = 0` contributes zero for every input value, whatever its table slot holds.
- R5: No input combination causes a sum to overflow `AW` bits. This includes inputs that drive every contribution of an output to its largest or smallest table value.
- R6: `out_valid` is high exactly `1 + ceil(log2 N_IN)` cycles after the cycle in which `in_valid` was sampled high. The sums shown in that cycle belong to the vector sampled with that strobe.
- R7: Vectors presented on consecutive cycles each produce their own correct result on consecutive cycles. The layer accepts one vector per cycle.
- R8: While `rst` is high and for the first cycles after it falls, `out_valid` is low and every sum reads zero. This holds even when `in_valid` is held high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_act` as a vector to process |
| in_act | input | N_IN*XW | Input activations, word `i` at `[i*XW +: XW]` |
| out_valid | output | 1 | Marks `out_sum` as a finished result |
| out_sum | output | N_OUT*AW | Signed sums, output `o` at `[o*AW +: AW]` |

## Verification
The bench builds the layer with 5 inputs, 3 outputs, 6-bit activations and a width ceiling of 4. This gives an unbalanced three-level tree padded from 5 to 8 leaves and a 4-cycle latency. Every connection width from 0 to 4 occurs, including pruning on the address side and on the result side, and every address width narrower than the input word, so wrapping is always active. That size makes it practical to sweep every one of the 64 activation values on each input in turn and on all inputs together, to walk the per-output extremes, and to stream hundreds of random vectors with gaps. All expected sums come from closed-form table and width formulas.

// File: rtl/lutmap_pkg.sv
package lutmap_pkg;

  // width field size for each connection's address / result width
  localparam int WF = 4;

  // default build
  localparam int DEF_N_IN  = 16;
  localparam int DEF_N_OUT = 5;
  localparam int DEF_MAXW  = 6;
  localparam int DEF_XW    = 6;
  localparam int DEF_EDGES = DEF_N_IN * DEF_N_OUT;
  localparam int DEF_ENT   = 1 << DEF_MAXW;
  localparam int DEF_SLOT  = DEF_ENT * DEF_MAXW;

  // output 0 reads every input at full width, the rest vary from 0 to 6 bits
  function automatic logic [DEF_EDGES*WF-1:0] def_in_w();
    logic [DEF_EDGES*WF-1:0] r;
    r = '0;
    for (int o = 0; o < DEF_N_OUT; o++) begin
      for (int i = 0; i < DEF_N_IN; i++) begin
        int w;
        w = (o == 0) ? DEF_MAXW : (i + 2*o) % (DEF_MAXW + 1);
        r[(o*DEF_N_IN + i)*WF +: WF] = WF'(w);
      end
    end
    return r;
  endfunction

  function automatic logic [DEF_EDGES*WF-1:0] def_out_w();
    logic [DEF_EDGES*WF-1:0] r;
    r = '0;
    for (int o = 0; o < DEF_N_OUT; o++) begin
      for (int i = 0; i < DEF_N_IN; i++) begin
        int w;
        w = (o == 0) ? (i % DEF_MAXW) + 1 : (3*i + o) % (DEF_MAXW + 1);
        r[(o*DEF_N_IN + i)*WF +: WF] = WF'(w);
      end
    end
    return r;
  endfunction

  function automatic logic [DEF_EDGES*DEF_SLOT-1:0] def_tables();
    logic [DEF_EDGES*DEF_SLOT-1:0] r;
    r = '0;
    for (int e = 0; e < DEF_EDGES; e++) begin
      for (int a = 0; a < DEF_ENT; a++) begin
        int v;
        v = (a*5 + e*11 + 3) % DEF_ENT;
        r[(e*DEF_ENT + a)*DEF_MAXW +: DEF_MAXW] = DEF_MAXW'(v);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/lutmap_edge.sv
// One surviving connection: wrapped address -> table code -> sign extension.
module lutmap_edge #(
  parameter int BI   = 1,
  parameter int BO   = 1,
  parameter int MAXW = 6,
  parameter int AW   = 10,
  parameter logic [(2**MAXW)*MAXW-1:0] SLOT = '0
) (
  input  logic [BI-1:0]        addr,
  output logic signed [AW-1:0] y
);

  logic [BO-1:0] code;

  // each entry sits in a MAXW-wide slot; only the low BO bits are meaningful
  always_comb begin
    code = SLOT[addr*MAXW +: BO];
  end

  assign y = {{(AW-BO){code[BO-1]}}, code};

endmodule

// File: rtl/lutmap_sumtree.sv
// Balanced adder tree, one register per level, leaves padded to a power of two.
module lutmap_sumtree #(
  parameter int N  = 16,
  parameter int W  = 10,
  parameter int LW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N*W-1:0]      leaf,
  output logic signed [W-1:0] root
);

  localparam int LV = $clog2(N);
  localparam int P  = 1 << LV;

  // node numbering: leaves 0..P-1, then level 1, level 2, ... root at 2P-2
  function automatic int base(int l);
    return 2*P - 2*(P >> l);
  endfunction

  logic signed [W-1:0] all_n [2*P-1];
  logic signed [W-1:0] nd_q  [P-1];

  always_comb begin
    for (int k = 0; k < P; k++) begin
      if (k < N) all_n[k] = leaf[k*W +: W];
      else       all_n[k] = '0;
    end
    for (int k = 0; k < P-1; k++) all_n[P+k] = nd_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < P-1; k++) nd_q[k] <= '0;
    end else begin
      for (int l = 1; l <= LV; l++) begin
        for (int j = 0; j < P/2; j++) begin
          if (j < (P >> l))
            nd_q[base(l) - P + j] <= all_n[base(l-1) + 2*j] + all_n[base(l-1) + 2*j + 1];
        end
      end
    end
  end

  assign root = nd_q[P-2];

  // every leaf must be a properly sign-extended code of at most LW bits
  for (genvar j = 0; j < N; j++) begin : g_leaf_chk
    AST_LEAF_RANGE: assert property (@(posedge clk) disable iff (rst)
      ($signed(all_n[j]) >= -(1 << (LW-1))) && ($signed(all_n[j]) <= (1 << (LW-1)) - 1)); // R3
  end

  AST_ROOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    ($signed(root) >= -N*(1 << (LW-1))) && ($signed(root) <= N*((1 << (LW-1)) - 1))); // R5

endmodule

// File: rtl/lutmap_layer.sv
module lutmap_layer #(
  parameter int N_IN  = lutmap_pkg::DEF_N_IN,
  parameter int N_OUT = lutmap_pkg::DEF_N_OUT,
  parameter int XW    = lutmap_pkg::DEF_XW,
  parameter int MAXW  = lutmap_pkg::DEF_MAXW,
  parameter logic [N_IN*N_OUT*lutmap_pkg::WF-1:0] IN_W  = lutmap_pkg::def_in_w(),
  parameter logic [N_IN*N_OUT*lutmap_pkg::WF-1:0] OUT_W = lutmap_pkg::def_out_w(),
  parameter logic [N_IN*N_OUT*(2**MAXW)*MAXW-1:0] TABLES = lutmap_pkg::def_tables()
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  in_valid,
  input  logic [N_IN*XW-1:0]                    in_act,
  output logic                                  out_valid,
  output logic [N_OUT*(MAXW+$clog2(N_IN))-1:0]  out_sum
);

  localparam int WF  = lutmap_pkg::WF;
  localparam int AW  = MAXW + $clog2(N_IN);
  localparam int LV  = $clog2(N_IN);
  localparam int LAT = 1 + LV;
  localparam int SW  = (2**MAXW) * MAXW;
  localparam int CW  = $clog2(LAT + 1) + 1;

  logic [N_IN*XW-1:0] x_q;
  logic [LAT-1:0]     vsr;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      vsr <= '0;
    end else begin
      x_q <= in_act;
      vsr <= {vsr[LAT-2:0], in_valid};
    end
  end

  assign out_valid = vsr[LAT-1];

  logic signed [AW-1:0] root_w [N_OUT];

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    wire [N_IN*AW-1:0] lf;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
      localparam int E  = o*N_IN + i;
      localparam int BI = int'(IN_W[E*WF +: WF]);
      localparam int BO = int'(OUT_W[E*WF +: WF]);

      if (BI == 0 || BO == 0) begin : g_cut
        assign lf[i*AW +: AW] = '0;
      end else begin : g_lut
        lutmap_edge #(
          .BI(BI), .BO(BO), .MAXW(MAXW), .AW(AW),
          .SLOT(TABLES[E*SW +: SW])
        ) u_edge (
          .addr(x_q[i*XW +: BI]),
          .y   (lf[i*AW +: AW])
        );
      end
    end

    lutmap_sumtree #(.N(N_IN), .W(AW), .LW(MAXW)) u_tree (
      .clk (clk),
      .rst (rst),
      .leaf(lf),
      .root(root_w[o])
    );
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++) out_sum[o*AW +: AW] = root_w[o];
  end

  // cycles since reset, saturating at the pipeline depth
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != CW'(LAT)) since_rst <= since_rst + 1'b1;
  end

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && out_sum == '0)); // R8

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == CW'(LAT)) |-> (out_valid == $past(in_valid, LAT))); // R6

endmodule

// File: tb/sim_lutmap_layer.sv
module sim_lutmap_layer;

  localparam int NI  = 5;
  localparam int NO  = 3;
  localparam int XW  = 6;
  localparam int MW  = 4;
  localparam int AW  = MW + 3;
  localparam int LAT = 4;
  localparam int NE  = NI * NO;
  localparam int ENT = 1 << MW;

  function automatic int bin_of(int e);  return e % 5;           endfunction
  function automatic int bout_of(int e); return (2*e + 1) % 5;   endfunction
  function automatic int tbl_of(int e, int a); return (a*7 + e*3 + 1) & 15; endfunction

  function automatic logic [NE*4-1:0] mk_in_w();
    logic [NE*4-1:0] r;
    for (int e = 0; e < NE; e++) r[e*4 +: 4] = 4'(bin_of(e));
    return r;
  endfunction

  function automatic logic [NE*4-1:0] mk_out_w();
    logic [NE*4-1:0] r;
    for (int e = 0; e < NE; e++) r[e*4 +: 4] = 4'(bout_of(e));
    return r;
  endfunction

  function automatic logic [NE*ENT*MW-1:0] mk_tab();
    logic [NE*ENT*MW-1:0] r;
    for (int e = 0; e < NE; e++)
      for (int a = 0; a < ENT; a++) r[(e*ENT + a)*MW +: MW] = MW'(tbl_of(e, a));
    return r;
  endfunction

  // contribution of connection e for activation pattern v
  function automatic int edge_val(int e, int v);
    int bi, bo, a, c;
    bi = bin_of(e);
    bo = bout_of(e);
    if (bi == 0 || bo == 0) return 0;
    a = v & ((1 << bi) - 1);
    c = tbl_of(e, a) & ((1 << bo) - 1);
    if (c >= (1 << (bo-1))) c = c - (1 << bo);
    return c;
  endfunction

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [NI*XW-1:0]  in_act = '0;
  logic              out_valid;
  logic [NO*AW-1:0]  out_sum;

  always #5 clk = ~clk;

  lutmap_layer #(
    .N_IN(NI), .N_OUT(NO), .XW(XW), .MAXW(MW),
    .IN_W(mk_in_w()), .OUT_W(mk_out_w()), .TABLES(mk_tab())
  ) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_act(in_act),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  int cyc = 0;
  int xs [NI];
  bit    hv [0:4095];
  int    hs [0:4095][NO];
  string ht [0:4095];

  function automatic int model(int o);
    int s = 0;
    for (int i = 0; i < NI; i++) s += edge_val(o*NI + i, xs[i]);
    return s;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int sum_of(int o);
    return $signed(out_sum[o*AW +: AW]);
  endfunction

  // called just after a falling edge: check the result due now, then drive
  task automatic step(input bit v, input string tag);
    if (cyc >= LAT) begin
      chk($sformatf("R6 valid at cycle %0d", cyc), int'(out_valid), int'(hv[cyc-LAT]));
      if (hv[cyc-LAT])
        for (int o = 0; o < NO; o++)
          chk($sformatf("%s out%0d vector %0d", ht[cyc-LAT], o, cyc-LAT), sum_of(o), hs[cyc-LAT][o]);
    end else begin
      chk($sformatf("R8 quiet after reset cycle %0d", cyc), int'(out_valid), 0);
    end
    in_valid = v;
    for (int i = 0; i < NI; i++) in_act[i*XW +: XW] = XW'(xs[i]);
    hv[cyc] = v;
    for (int o = 0; o < NO; o++) hs[cyc][o] = model(o);
    ht[cyc] = tag;
    cyc++;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NI; i++) xs[i] = 0;
    // reset with a live strobe and busy inputs: nothing may emerge (R8)
    @(negedge clk);
    in_valid = 1'b1;
    in_act = '1;
    repeat (3) begin
      @(negedge clk);
      chk("R8 valid in reset", int'(out_valid), 0);
      for (int o = 0; o < NO; o++) chk($sformatf("R8 sum%0d in reset", o), sum_of(o), 0);
    end
    rst = 1'b0;

    // input 0 reaches only pruned connections: outputs stay fixed (R4)
    for (int v = 0; v < 64; v++) begin
      xs[0] = v;
      step(1'b1, "R4 pruned input 0");
    end
    xs[0] = 0;

    // every other input swept alone through all 64 patterns, high bits wrap (R2)
    for (int i = 1; i < NI; i++) begin
      for (int v = 0; v < 64; v++) begin
        xs[i] = v;
        step(1'b1, $sformatf("R2 wrap input %0d", i));
      end
      xs[i] = 0;
    end

    // all inputs equal, back to back, exercises every result width (R3, R7)
    for (int v = 0; v < 64; v++) begin
      for (int i = 0; i < NI; i++) xs[i] = v;
      step(1'b1, "R3/R7 common value");
    end

    // per-output extremes (R5)
    for (int o = 0; o < NO; o++) begin
      for (int dir = 0; dir < 2; dir++) begin
        for (int i = 0; i < NI; i++) begin
          int best = 0;
          for (int v = 1; v < 64; v++) begin
            int cand = edge_val(o*NI + i, v);
            int cur  = edge_val(o*NI + i, best);
            if ((dir == 0 && cand > cur) || (dir == 1 && cand < cur)) best = v;
          end
          xs[i] = best;
        end
        step(1'b1, $sformatf("R5 extreme out%0d dir%0d", o, dir));
      end
    end

    // random vectors with random gaps in the strobe (R1)
    for (int n = 0; n < 800; n++) begin
      for (int i = 0; i < NI; i++) xs[i] = int'($urandom_range(0, 63));
      step(($urandom_range(0, 3) != 0), "R1 random sum");
    end

    for (int n = 0; n < LAT + 2; n++) step(1'b0, "R6 drain");

    finish_run();
  end

endmodule